// File: doc/BRIEF.md
# Vector Condition-Field Fail-First Sequencer

This block walks the elements of a vectorised condition-register operation one per cycle, starting at element 0. An external element unit returns a 4-bit condition field for the element whose index the sequencer presents. The sequencer picks one bit of that field and compares it with an invert flag. The first enabled element whose bit matches the flag ends the walk and truncates the vector length. Elements with a clear predicate bit are stepped over without being examined.

The tested bit has two possible sources. When the operation names a whole 4-bit field, a 2-bit selector inside the mode bits chooses the bit. When the operation names a single bit of the full register, the selector is the low two bits of its destination operand. An inclusive option keeps the failing element inside the new length instead of cutting just before it. The mode decode also identifies the other mode families. Plain and predicate-result modes write every enabled element with no test. The reserved code produces no writes at all.

Top module: `crff_seq`

## Requirements
- R1: After reset `done`, `wr_en`, `elem_idx` and `final_vl` are 0, and `wr_en` stays 0 whenever no operation is running.
- R2: After a `start` pulse, `elem_idx` is 0 in the first cycle and rises by one each cycle until the run ends. A `vlen` above `MAX_VL` is treated as `MAX_VL`.
- R3: Mode code `{mode_sel[1],mode_sel[0]}` = 01 is fail-first. With `bit_form` = 0, selector s = `mode_ext` picks `cr_field[3-s]`. An enabled element passes when that bit differs from `mode_inv`, and a passing element raises `wr_en` in its cycle.
- R4: With `bit_form` = 1 the selector is `dst_crbit` and `mode_ext` is ignored. The pass rule is the same as in R3.
- R5: An element whose `pred_mask` bit is 0 gets no write and is not tested, so it never ends the run.
- R6: On the first failing element with `mode_vli` = 0, there is no write for that element, the run ends, and `final_vl` becomes its index.
- R7: On the first failing element with `mode_vli` = 1, that element is written, the run ends, and `final_vl` becomes its index plus one.
- R8: If no element fails, `final_vl` equals the effective length. `done` is high for exactly one cycle, in the cycle after the last processed element.
- R9: A zero effective length raises `done` in the cycle after `start`, with no writes and `final_vl` = 0.
- R10: Mode code 10 is reserved. It raises `done` in the cycle after `start`, with no writes and `final_vl` = 0.
- R11: Mode codes 00 and 11 write every enabled element with no bit test, and `final_vl` equals the effective length.
- R12: A `start` while a run is active is ignored. The length, mask, mode and selector in use are the ones captured at the accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (captured when idle) |
| mode_sel | input | 2 | Mode family code: [1] = field bit 19, [0] = field bit 20 |
| mode_inv | input | 1 | Invert flag (field bit 21) |
| mode_vli | input | 1 | Inclusive-length flag (field bit 5) |
| mode_ext | input | 2 | Bit selector for field operands: [1] = bit 22, [0] = bit 23 |
| bit_form | input | 1 | 1 when the operation names a single register bit |
| dst_crbit | input | 2 | Low two bits of the destination bit operand |
| vlen | input | VL_W | Requested vector length |
| pred_mask | input | MAX_VL | Element enable mask, bit i for element i |
| cr_field | input | 4 | Condition field result for element `elem_idx` |
| elem_idx | output | IDX_W | Element being processed |
| wr_en | output | 1 | Store the result of the current element |
| final_vl | output | VL_W | Truncated length of the last finished run |
| done | output | 1 | One-cycle pulse when a run finishes |

## Verification
Several properties are checked on every cycle: no write happens outside a run, and a masked element never writes or fails. The index steps by one until the last element, an ignored `start` does not disturb the step, and `done` is a single pulse. A failing element's write follows the inclusive flag, and the next length is its index or its index plus one. The bench scenarios show what these cycle-level rules cannot. These include the complete write pattern and final length over every mask, fail pattern, invert and inclusive setting, and both selector sources with decoy bits set opposite. They also cover the exact cycle of `done`, the clamp of oversize lengths, and the capture of the inputs at the accepted `start`.

// File: rtl/crff_pkg.sv
package crff_pkg;

  typedef enum logic [1:0] {
    MD_NORMAL = 2'b00,
    MD_FFIRST = 2'b01,
    MD_RSVD   = 2'b10,
    MD_PRED   = 2'b11
  } md_e;

  typedef struct packed {
    md_e        md;
    logic       inv;
    logic       vli;
    logic [1:0] sel;
  } ffcfg_t;

  // Combine the raw mode bits into one configuration word.
  function automatic ffcfg_t decode_cfg(logic [1:0] msel, logic minv, logic mvli,
                                        logic [1:0] mext, logic bform, logic [1:0] dbit);
    ffcfg_t c;
    c.md  = md_e'(msel);
    c.inv = minv;
    c.vli = mvli;
    c.sel = bform ? dbit : mext;
    return c;
  endfunction

  // Selector 0 names the most significant bit of the field.
  function automatic logic pick_crbit(logic [3:0] f, logic [1:0] s);
    logic b;
    case (s)
      2'd0:    b = f[3];
      2'd1:    b = f[2];
      2'd2:    b = f[1];
      default: b = f[0];
    endcase
    return b;
  endfunction

endpackage

// File: rtl/crff_decode.sv
module crff_decode
  import crff_pkg::*;
(
  input  logic [1:0] mode_sel,
  input  logic       mode_inv,
  input  logic       mode_vli,
  input  logic [1:0] mode_ext,
  input  logic       bit_form,
  input  logic [1:0] dst_crbit,
  output ffcfg_t     cfg
);
  always_comb cfg = decode_cfg(mode_sel, mode_inv, mode_vli, mode_ext, bit_form, dst_crbit);
endmodule

// File: rtl/crff_eval.sv
module crff_eval
  import crff_pkg::*;
(
  input  logic       busy,
  input  ffcfg_t     cfg,
  input  logic       pred_bit,
  input  logic [3:0] cr_field,
  output logic       wr,
  output logic       fail
);
  logic live;
  logic tested;

  always_comb begin
    live   = busy & pred_bit;
    tested = pick_crbit(cr_field, cfg.sel);
    fail   = live & (cfg.md == MD_FFIRST) & (tested == cfg.inv);
    wr     = live & (~fail | cfg.vli);
  end
endmodule

// File: rtl/crff_ctrl.sv
module crff_ctrl
  import crff_pkg::*;
#(
  parameter int MAX_VL = 8,
  localparam int IDX_W = $clog2(MAX_VL),
  localparam int VL_W  = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  ffcfg_t            cfg_in,
  input  logic [VL_W-1:0]   vlen,
  input  logic [MAX_VL-1:0] pred_in,
  input  logic              fail,
  output logic              busy,
  output logic [IDX_W-1:0]  idx,
  output ffcfg_t            cfg_q,
  output logic              cur_pred,
  output logic              last_ev,
  output logic              done,
  output logic [VL_W-1:0]   final_vl
);

  function automatic logic [VL_W-1:0] clamp_len(logic [VL_W-1:0] v);
    return (v > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : v;
  endfunction

  function automatic logic [VL_W-1:0] trunc_len(logic hit, logic keep,
                                                logic [IDX_W-1:0] i, logic [VL_W-1:0] v);
    if (!hit) return v;
    return VL_W'(i) + (keep ? VL_W'(1) : VL_W'(0));
  endfunction

  logic              busy_q;
  logic [IDX_W-1:0]  idx_q;
  logic [VL_W-1:0]   vl_q;
  logic [MAX_VL-1:0] pred_q;
  logic              done_q;
  logic [VL_W-1:0]   fin_q;
  logic [VL_W-1:0]   eff_len;
  logic              empty_run;

  always_comb begin
    eff_len   = clamp_len(vlen);
    empty_run = (eff_len == '0) | (cfg_in.md == MD_RSVD);
  end

  assign busy     = busy_q;
  assign idx      = idx_q;
  assign cur_pred = pred_q[idx_q];
  assign last_ev  = busy_q & (fail | (VL_W'(idx_q) == vl_q - VL_W'(1)));
  assign done     = done_q;
  assign final_vl = fin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      vl_q   <= '0;
      pred_q <= '0;
      cfg_q  <= '0;
      done_q <= 1'b0;
      fin_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          cfg_q  <= cfg_in;
          pred_q <= pred_in;
          vl_q   <= eff_len;
          idx_q  <= '0;
          if (empty_run) begin
            done_q <= 1'b1;
            fin_q  <= '0;
          end else begin
            busy_q <= 1'b1;
          end
        end
      end else if (last_ev) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        fin_q  <= trunc_len(fail, cfg_q.vli, idx_q, vl_q);
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/crff_seq.sv
module crff_seq
  import crff_pkg::*;
#(
  parameter int MAX_VL = 8,
  localparam int IDX_W = $clog2(MAX_VL),
  localparam int VL_W  = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode_sel,
  input  logic              mode_inv,
  input  logic              mode_vli,
  input  logic [1:0]        mode_ext,
  input  logic              bit_form,
  input  logic [1:0]        dst_crbit,
  input  logic [VL_W-1:0]   vlen,
  input  logic [MAX_VL-1:0] pred_mask,
  input  logic [3:0]        cr_field,
  output logic [IDX_W-1:0]  elem_idx,
  output logic              wr_en,
  output logic [VL_W-1:0]   final_vl,
  output logic              done
);

  ffcfg_t cfg_in;
  ffcfg_t cfg_q;
  logic   busy;
  logic   cur_pred;
  logic   fail_ev;
  logic   last_ev;

  crff_decode u_dec (
    .mode_sel (mode_sel),
    .mode_inv (mode_inv),
    .mode_vli (mode_vli),
    .mode_ext (mode_ext),
    .bit_form (bit_form),
    .dst_crbit(dst_crbit),
    .cfg      (cfg_in)
  );

  crff_eval u_eval (
    .busy    (busy),
    .cfg     (cfg_q),
    .pred_bit(cur_pred),
    .cr_field(cr_field),
    .wr      (wr_en),
    .fail    (fail_ev)
  );

  crff_ctrl #(.MAX_VL(MAX_VL)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .cfg_in  (cfg_in),
    .vlen    (vlen),
    .pred_in (pred_mask),
    .fail    (fail_ev),
    .busy    (busy),
    .idx     (elem_idx),
    .cfg_q   (cfg_q),
    .cur_pred(cur_pred),
    .last_ev (last_ev),
    .done    (done),
    .final_vl(final_vl)
  );
endmodule

// File: rtl/crff_seq_chk.sv
module crff_seq_chk #(
  parameter int MAX_VL = 8,
  localparam int IDX_W = $clog2(MAX_VL),
  localparam int VL_W  = $clog2(MAX_VL + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [1:0]       mode_sel,
  input logic [VL_W-1:0]  vlen,
  input logic             busy,
  input logic             cur_pred,
  input logic             fail_ev,
  input logic             last_ev,
  input logic             vli_q,
  input logic [IDX_W-1:0] elem_idx,
  input logic             wr_en,
  input logic [VL_W-1:0]  final_vl,
  input logic             done
);
  logic [VL_W-1:0] idx_ext;
  assign idx_ext = VL_W'(elem_idx);

  // R1
  idle_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !wr_en);
  // R2
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !last_ev |=> busy && idx_ext == $past(idx_ext) + VL_W'(1));
  // R5
  masked_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !cur_pred |-> !wr_en && !fail_ev);
  // R6
  cut_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_ev && !vli_q |-> !wr_en);
  // R6
  cut_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_ev && !vli_q |=> final_vl == $past(idx_ext));
  // R7
  keep_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_ev && vli_q |-> wr_en);
  // R7
  keep_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_ev && vli_q |=> final_vl == $past(idx_ext) + VL_W'(1));
  // R8
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_ev |=> done && !busy);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R9
  empty_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && vlen == '0 |=> done && !busy && final_vl == '0);
  // R10
  rsvd_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && mode_sel == 2'b10 |=> done && !busy && final_vl == '0);
  // R12
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !last_ev |=> busy && !done);
endmodule

bind crff_seq crff_seq_chk #(.MAX_VL(MAX_VL)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .mode_sel(mode_sel),
  .vlen    (vlen),
  .busy    (busy),
  .cur_pred(cur_pred),
  .fail_ev (fail_ev),
  .last_ev (last_ev),
  .vli_q   (cfg_q.vli),
  .elem_idx(elem_idx),
  .wr_en   (wr_en),
  .final_vl(final_vl),
  .done    (done)
);

// File: tb/crff_seq_bench.sv
module crff_seq_bench;
  localparam int MAXV = 4;
  localparam int IW   = $clog2(MAXV);
  localparam int VLW  = $clog2(MAXV + 1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [1:0]      mode_sel = '0;
  logic            mode_inv = 1'b0;
  logic            mode_vli = 1'b0;
  logic [1:0]      mode_ext = '0;
  logic            bit_form = 1'b0;
  logic [1:0]      dst_crbit = '0;
  logic [VLW-1:0]  vlen = '0;
  logic [MAXV-1:0] pred_mask = '0;
  logic [3:0]      cr_field;
  logic [IW-1:0]   elem_idx;
  logic            wr_en;
  logic [VLW-1:0]  final_vl;
  logic            done;

  logic [3:0] cr_tab [MAXV];
  int errs = 0;
  int checks = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  always_comb cr_field = cr_tab[elem_idx];

  crff_seq #(.MAX_VL(MAXV)) u_crff_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_sel(mode_sel),
    .mode_inv(mode_inv), .mode_vli(mode_vli), .mode_ext(mode_ext),
    .bit_form(bit_form), .dst_crbit(dst_crbit), .vlen(vlen),
    .pred_mask(pred_mask), .cr_field(cr_field), .elem_idx(elem_idx),
    .wr_en(wr_en), .final_vl(final_vl), .done(done)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errs++;
      checks++;
      $display("FAIL watchdog R2: act=%0d exp=%0d", cyc, 190000);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] code, input logic inv, input logic vli,
                        input logic form, input logic [1:0] sel, input int v,
                        input int pm, input int pat, input bit disturb);
    int ev, np, eff, j, dj;
    logic [MAXV-1:0] em, gm, pmask;
    bit failed, idx_ok;
    string tg;
    pmask = pm[MAXV-1:0];
    for (int i = 0; i < MAXV; i++) begin
      logic pb;
      pb = pat[i];
      cr_tab[i] = {4{~pb}} ^ (4'b0001 << (3 - sel));
    end
    // expected behaviour
    eff = (v > MAXV) ? MAXV : v;
    ev = eff; np = 0; em = '0; failed = 0;
    if (code == 2'b10) ev = 0;
    else begin
      for (int i = 0; i < eff; i++) begin
        np = i + 1;
        if (!pmask[i]) continue;
        if (code != 2'b01) begin em[i] = 1'b1; continue; end
        if (pat[i] != inv) em[i] = 1'b1;
        else begin
          failed = 1;
          if (vli) begin em[i] = 1'b1; ev = i + 1; end
          else ev = i;
          break;
        end
      end
    end
    if (code == 2'b10) tg = "R10";
    else if (disturb) tg = "R12";
    else if (v > MAXV) tg = "R2";
    else if (eff == 0) tg = "R9";
    else if (code != 2'b01) tg = "R11";
    else if (failed) tg = vli ? "R7" : "R6";
    else tg = form ? "R4" : "R3";
    // drive
    @(negedge clk);
    mode_sel = code; mode_inv = inv; mode_vli = vli; bit_form = form;
    mode_ext = form ? ~sel : sel;
    dst_crbit = form ? sel : ~sel;
    vlen = VLW'(v); pred_mask = pmask; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    j = 0; dj = -1; gm = '0; idx_ok = 1;
    while (j < MAXV + 3) begin
      if (done) begin dj = j; break; end
      if (int'(elem_idx) != j) idx_ok = 0;
      if (wr_en) gm[elem_idx] = 1'b1;
      if (disturb && j == 0) begin
        start = 1'b1; vlen = '0; pred_mask = '0; mode_sel = 2'b10;
        mode_inv = ~inv; mode_ext = ~mode_ext; dst_crbit = ~dst_crbit;
      end
      if (disturb && j == 1) start = 1'b0;
      @(negedge clk);
      j++;
    end
    start = 1'b0;
    chk(gm == em, tg, int'(gm), int'(em));
    chk((gm & ~pmask) == '0, "R5", int'(gm), int'(em));
    chk(int'(final_vl) == ev, failed ? tg : "R8", int'(final_vl), ev);
    chk(dj == np, "R8", dj, np);
    chk(idx_ok, "R2", idx_ok, 1);
    @(negedge clk);
    chk(!done && !wr_en, "R8", {done, wr_en}, 0);
  endtask

  initial begin
    for (int i = 0; i < MAXV; i++) cr_tab[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!done && !wr_en && elem_idx == '0 && final_vl == '0, "R1",
        {done, wr_en, elem_idx, final_vl}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !wr_en && final_vl == '0, "R1", {done, wr_en, final_vl}, 0);
    // fail-first sweep: R3 R4 R5 R6 R7 R8 R9
    for (int v = 0; v <= MAXV; v++)
      for (int pm = 0; pm < (1 << MAXV); pm++)
        for (int pat = 0; pat < (1 << MAXV); pat++)
          for (int k = 0; k < 8; k++)
            run_op(2'b01, k[0], k[1], k[2], 2'((pm + pat + k) % 4), v, pm, pat, 0);
    // other mode families and oversize lengths: R10 R11 R2
    for (int c = 0; c < 4; c++)
      if (c != 1)
        for (int v = 0; v <= MAXV + 2; v++)
          for (int pm = 0; pm < (1 << MAXV); pm++)
            run_op(2'(c), pm[0], pm[1], pm[2], 2'(pm % 4), v, pm, pm ^ 5, 0);
    for (int v = MAXV + 1; v < (1 << VLW); v++)
      run_op(2'b01, 1'b0, 1'b1, 1'b0, 2'(v % 4), v, 15, 5'h1b, 0);
    // start during a run: R12
    for (int k = 0; k < 8; k++) begin
      run_op(2'b01, k[0], k[1], k[2], 2'(k % 4), MAXV, (1 << MAXV) - 1,
             k[0] ? 0 : (1 << MAXV) - 1, 1);
      run_op(2'b00, k[0], k[1], k[2], 2'(k % 4), MAXV, 4'hb, 0, 1);
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule